// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block controls a nonvolatile SRAM model built from a working SRAM array paired with a shadow nonvolatile array of the same size. A STORE copies the whole SRAM image into the shadow array, and a RECALL copies the shadow image back into the SRAM. Each operation takes a fixed number of clock cycles, set by a parameter. The copy of the whole image takes effect on the last cycle of the operation. While an operation runs, the `busy` output is high. During that time the external chip-enable, output-enable and write-enable bus has no effect, and any new trigger is dropped.

There are four sources of a RECALL or STORE:
- Reset stands for the first power-on. It starts a RECALL at once, so the SRAM is loaded from the shadow array. Reset also loads the shadow array with a fixed factory image.
- A rising edge on the power-fail input requests a STORE. A falling edge on the same input means power has come back and requests a RECALL.
- A falling edge on the active-low hardware-store pin requests a STORE.
- Single-cycle strobes from a separate software command detector request a STORE or a RECALL.

A dirty flag records whether the SRAM has been written since the last completed operation. Any STORE request that finds the flag clear is skipped and starts no operation. After an operation completes, a write that is still being held on the bus stays blocked until write-enable makes a new high-to-low transition.

Top module: `nvs_sequencer`

## Requirements
- R1: Reset starts a RECALL at once. `busy` is high during reset and for RECALL_CYC cycles after reset is released. Reset loads shadow word i with (37*i+5) mod 2^WIDTH. After that first RECALL, a read of any address returns the shadow word for that address, and `dirty` is 0.
- R2: A read is accepted in a cycle when all of these hold: `busy` is low, `ce_n`=0, `oe_n`=0, `we_n`=1 and `hw_store_n`=1. In the next cycle `rd_valid` is 1 and `rdata` holds the SRAM word at `addr`. In every other case `rd_valid` is 0 in the next cycle.
- R3: A write is accepted in a cycle when all of these hold: `busy` is low, `ce_n`=0, `we_n`=0, `hw_store_n`=1, and the write lock is clear. An accepted write stores `wdata` at `addr` and sets `dirty` to 1.
- R4: A rising edge of `pwr_fail` requests a STORE lasting STORE_CYC cycles. A falling edge of `pwr_fail` requests a RECALL lasting RECALL_CYC cycles.
- R5: A high-to-low edge of `hw_store_n` requests a STORE.
- R6: A pulse on `sw_store` requests a STORE. A pulse on `sw_recall` requests a RECALL. Either request is taken up in the cycle of the pulse.
- R7: A STORE request made while `dirty` is 0 is skipped. `busy` stays low and both arrays are unchanged.
- R8: On the last cycle of an operation, the whole image is copied: the SRAM into the shadow array for a STORE, or the shadow array into the SRAM for a RECALL. In that same cycle `dirty` is cleared.
- R9: While `busy` is high, reads and writes are ignored, and triggers that arrive are dropped. A dropped trigger does not start an operation later.
- R10: When several requests arrive in one cycle, only the highest-priority one is taken. The order from highest to lowest is: `pwr_fail` rise, `pwr_fail` fall, `hw_store_n` fall, `sw_store`, `sw_recall`.
- R11: If `ce_n` and `we_n` are both 0 in the cycle an operation completes, writes stay blocked until a cycle in which `we_n` is sampled at 1.
- R12: While `hw_store_n` is 0, no read or write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; stands for first power-on |
| pwr_fail | input | 1 | Power-fail detect: rising edge requests STORE, falling edge requests RECALL |
| hw_store_n | input | 1 | Active-low hardware store pin; must be high for bus cycles |
| sw_store | input | 1 | Software STORE command strobe |
| sw_recall | input | 1 | Software RECALL command strobe |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | A read was accepted in the previous cycle |
| busy | output | 1 | A STORE or RECALL is in progress |
| dirty | output | 1 | SRAM written since the last completed operation |

## Verification
The embedded assertions check these properties on every cycle:
- At most one operation starts in a cycle, and a STORE never starts with a clean image.
- No read or write is accepted while busy, while the hardware-store pin is low, or while the write lock holds with write-enable low.
- The operation counter stays inside the operation length.
- Completing an operation always leaves `dirty` clear, and a completed STORE leaves the shadow array equal to the SRAM.

Other behaviours can only be shown by the bench's scenarios, which track the image contents through time:
- A skipped STORE leaves the shadow array untouched.
- The priority order between simultaneous triggers.
- A recall after a power cycle restores the image taken before the write that followed it.
- A write held across a completion is blocked.
- A dropped trigger never restarts an operation.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nvs_op_e;

  // Factory image loaded into the shadow array at first power-on.
  function automatic logic [31:0] factory_word(input int unsigned idx);
    return 32'(idx * 32'd37 + 32'd5);
  endfunction

  // Trigger priority: power-down store, power-up recall, hardware store,
  // software store, software recall.
  function automatic nvs_op_e arbitrate(input logic pd_store, input logic pu_recall,
                                        input logic hw_store, input logic sws,
                                        input logic swr);
    if (pd_store)       return OP_STORE;
    else if (pu_recall) return OP_RECALL;
    else if (hw_store)  return OP_STORE;
    else if (sws)       return OP_STORE;
    else if (swr)       return OP_RECALL;
    else                return OP_IDLE;
  endfunction

endpackage

// File: rtl/nvs_trig_arb.sv
module nvs_trig_arb
  import nvs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic hw_store_n,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic idle,
  input  logic dirty,
  output logic start_store,
  output logic start_recall
);

  logic    pwr_q;
  logic    hw_q;
  logic    evt_pd;
  logic    evt_pu;
  logic    evt_hw;
  nvs_op_e winner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      hw_q  <= 1'b1;
    end else begin
      pwr_q <= pwr_fail;
      hw_q  <= hw_store_n;
    end
  end

  assign evt_pd = pwr_fail & ~pwr_q;
  assign evt_pu = ~pwr_fail & pwr_q;
  assign evt_hw = ~hw_store_n & hw_q;

  always_comb begin
    winner       = arbitrate(evt_pd, evt_pu, evt_hw, sw_store, sw_recall);
    start_store  = idle && (winner == OP_STORE) && dirty;
    start_recall = idle && (winner == OP_RECALL);
  end

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_store, start_recall})) else $error("two starts"); // R10
  AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    start_store |-> dirty) else $error("store on clean image"); // R7
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_store || start_recall) |-> idle) else $error("start while busy"); // R9

endmodule

// File: rtl/nvs_seq_ctrl.sv
module nvs_seq_ctrl
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 8,
  parameter int RECALL_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_store,
  input  logic start_recall,
  output logic busy,
  output logic store_done,
  output logic recall_done
);

  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  nvs_op_e         op_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   last_cnt;
  logic            at_end;

  function automatic logic [CW-1:0] op_last(input nvs_op_e op);
    return (op == OP_STORE) ? CW'(STORE_CYC - 1) : CW'(RECALL_CYC - 1);
  endfunction

  assign last_cnt    = op_last(op_q);
  assign busy        = (op_q != OP_IDLE);
  assign at_end      = busy && (cnt_q == last_cnt);
  assign store_done  = at_end && (op_q == OP_STORE);
  assign recall_done = at_end && (op_q == OP_RECALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_RECALL;
      cnt_q <= '0;
    end else if (op_q == OP_IDLE) begin
      cnt_q <= '0;
      if (start_store)       op_q <= OP_STORE;
      else if (start_recall) op_q <= OP_RECALL;
    end else if (at_end) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= last_cnt)) else $error("counter overrun"); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_end) |=> busy) else $error("op ended early"); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> !busy) else $error("op did not end"); // R8

endmodule

// File: rtl/nvs_bus_gate.sv
module nvs_bus_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic hw_store_n,
  input  logic busy,
  input  logic op_done,
  output logic rd_req,
  output logic wr_req,
  output logic dirty
);

  logic lock_q;
  logic dirty_q;
  logic bus_open;

  assign bus_open = ~busy & hw_store_n & ~ce_n;
  assign rd_req   = bus_open & ~oe_n & we_n;
  assign wr_req   = bus_open & ~we_n & ~lock_q;
  assign dirty    = dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      if (op_done)      lock_q <= ~ce_n & ~we_n;
      else if (we_n)    lock_q <= 1'b0;
      if (op_done)      dirty_q <= 1'b0;
      else if (wr_req)  dirty_q <= 1'b1;
    end
  end

  AST_NO_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(rd_req || wr_req)) else $error("access while busy"); // R9
  AST_HW_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_store_n |-> !(rd_req || wr_req)) else $error("access with pin low"); // R12
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !ce_n && !we_n) |=> (we_n || !wr_req)) else $error("held write passed"); // R11
  AST_DONE_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !dirty_q) else $error("dirty survived op"); // R8
  AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> dirty_q) else $error("write left clean"); // R3

endmodule

// File: rtl/nvs_mem_pair.sv
module nvs_mem_pair
  import nvs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              store_done,
  input  logic              recall_done,
  output logic [WIDTH-1:0]  rdata,
  output logic              rd_valid
);

  logic [WIDTH-1:0] sram_q   [DEPTH];
  logic [WIDTH-1:0] shadow_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;
  logic             rd_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        sram_q[i]   <= '0;
        shadow_q[i] <= WIDTH'(factory_word(i));
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_req && (addr == ADDR_W'(i))) sram_q[i] <= wdata;
        else if (recall_done)               sram_q[i] <= shadow_q[i];
        if (store_done)                     shadow_q[i] <= sram_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) rdata_q <= sram_q[addr];
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rd_valid_q;

  AST_STORE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> (shadow_q[DEPTH-1] == $past(sram_q[DEPTH-1]))) else $error("store copy"); // R8
  AST_RECALL_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    recall_done |=> (sram_q[0] == shadow_q[0])) else $error("recall copy"); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && (store_done || recall_done))) else $error("write during op"); // R9

endmodule

// File: rtl/nvs_sequencer.sv
module nvs_sequencer
  import nvs_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WIDTH      = 8,
  parameter int STORE_CYC  = 8,
  parameter int RECALL_CYC = 5,
  parameter int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              hw_store_n,
  input  logic              sw_store,
  input  logic              sw_recall,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              rd_valid,
  output logic              busy,
  output logic              dirty
);

  logic start_store;
  logic start_recall;
  logic store_done;
  logic recall_done;
  logic op_done;
  logic rd_req;
  logic wr_req;

  assign op_done = store_done | recall_done;

  nvs_trig_arb u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_fail     (pwr_fail),
    .hw_store_n   (hw_store_n),
    .sw_store     (sw_store),
    .sw_recall    (sw_recall),
    .idle         (~busy),
    .dirty        (dirty),
    .start_store  (start_store),
    .start_recall (start_recall)
  );

  nvs_seq_ctrl #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_store  (start_store),
    .start_recall (start_recall),
    .busy         (busy),
    .store_done   (store_done),
    .recall_done  (recall_done)
  );

  nvs_bus_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .hw_store_n (hw_store_n),
    .busy       (busy),
    .op_done    (op_done),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .dirty      (dirty)
  );

  nvs_mem_pair #(
    .DEPTH  (DEPTH),
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W)
  ) u_mem (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wdata       (wdata),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .store_done  (store_done),
    .recall_done (recall_done),
    .rdata       (rdata),
    .rd_valid    (rd_valid)
  );

endmodule

// File: tb/nvs_sequencer_tb_top.sv
module nvs_sequencer_tb_top;

  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int SCYC  = 8;
  localparam int RCYC  = 5;
  localparam int AW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0, hw_store_n = 1'b1, sw_store = 1'b0, sw_recall = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] rdata;
  logic rd_valid, busy, dirty;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  nvs_sequencer #(.DEPTH(DEPTH), .WIDTH(WIDTH), .STORE_CYC(SCYC), .RECALL_CYC(RCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .hw_store_n(hw_store_n),
    .sw_store(sw_store), .sw_recall(sw_recall), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .busy(busy), .dirty(dirty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 store, 2 recall
  int m_op, m_cnt, m_dirty, m_lock, m_pq, m_hq, m_rv, m_rd;
  int m_sram[DEPTH];
  int m_shadow[DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_op = 2; m_cnt = 0; m_dirty = 0; m_lock = 0; m_pq = 0; m_hq = 1; m_rv = 0; m_rd = 0;
      foreach (m_sram[i]) begin
        m_sram[i] = 0;
        m_shadow[i] = (i * 37 + 5) % 256;
      end
    end else begin
      int len, want;
      bit bsy, rd, wr, done, rise, fall, hwf;
      bsy  = (m_op != 0);
      rd   = !bsy && !ce_n && !oe_n && we_n && hw_store_n;
      wr   = !bsy && !ce_n && !we_n && hw_store_n && (m_lock == 0);
      len  = (m_op == 1) ? SCYC : RCYC;
      done = bsy && (m_cnt == len - 1);
      rise = pwr_fail && (m_pq == 0);
      fall = !pwr_fail && (m_pq == 1);
      hwf  = !hw_store_n && (m_hq == 1);
      m_rv = rd;
      if (rd) m_rd = m_sram[addr];
      if (wr) m_sram[addr] = wdata;
      if (done && m_op == 1) foreach (m_sram[i]) m_shadow[i] = m_sram[i];
      if (done && m_op == 2) foreach (m_sram[i]) m_sram[i] = m_shadow[i];
      if (done) m_lock = (!ce_n && !we_n) ? 1 : 0;
      else if (we_n) m_lock = 0;
      want = rise ? 1 : fall ? 2 : hwf ? 1 : sw_store ? 1 : sw_recall ? 2 : 0;
      if (!bsy) begin
        if (want == 1 && m_dirty == 1) begin m_op = 1; m_cnt = 0; end
        else if (want == 2) begin m_op = 2; m_cnt = 0; end
      end else if (done) begin
        m_op = 0; m_cnt = 0;
      end else m_cnt++;
      if (done) m_dirty = 0;
      else if (wr) m_dirty = 1;
      m_pq = pwr_fail;
      m_hq = hw_store_n;
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 busy vs model", busy, (m_op != 0));
      chk("R8 dirty vs model", dirty, m_dirty);
      chk("R2 rd_valid vs model", rd_valid, m_rv);
      if (m_rv != 0) chk("R2 rdata vs model", rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=%0d expected<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = AW'(a); wdata = WIDTH'(d);
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic do_read(input int a, input int exp, input string tag);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = AW'(a);
    @(negedge clk);
    chk({tag, " rd_valid"}, rd_valid, 1);
    chk({tag, " rdata"}, rdata, exp);
    ce_n = 1; oe_n = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R1 busy at power-up", busy, 1);
    wait_idle();
    do_read(3, (3 * 37 + 5) % 256, "R1 factory word 3");
    do_read(15, (15 * 37 + 5) % 256, "R1 factory word 15");
    chk("R1 clean after power-up", dirty, 0);

    do_write(2, 8'hA5);
    chk("R3 dirty after write", dirty, 1);
    do_read(2, 8'hA5, "R3 write readback");

    @(negedge clk); sw_store = 1;
    @(negedge clk); sw_store = 0;
    chk("R6 sw store busy", busy, 1);
    wait_idle();
    chk("R8 dirty cleared", dirty, 0);

    @(negedge clk); sw_store = 1;
    @(negedge clk); sw_store = 0;
    chk("R7 clean store skipped", busy, 0);

    do_write(2, 8'h11);
    @(negedge clk); sw_recall = 1;
    @(negedge clk); sw_recall = 0;
    chk("R6 sw recall busy", busy, 1);
    wait_idle();
    do_read(2, 8'hA5, "R6 recall restores");

    do_write(4, 8'h5A);
    @(negedge clk); sw_store = 1;
    @(negedge clk); sw_store = 0; sw_recall = 1; ce_n = 0; we_n = 0; addr = 4; wdata = 8'hFF;
    @(negedge clk); sw_recall = 0; ce_n = 1; we_n = 1;
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R9 dropped trigger", busy, 0);
    do_read(4, 8'h5A, "R9 write ignored while busy");

    @(negedge clk); hw_store_n = 0; ce_n = 0; oe_n = 0; addr = 4;
    @(negedge clk);
    chk("R12 read blocked", rd_valid, 0);
    oe_n = 1; we_n = 0; wdata = 8'h00;
    @(negedge clk); ce_n = 1; we_n = 1; hw_store_n = 1;
    chk("R12 write blocked dirty", dirty, 0);
    do_read(4, 8'h5A, "R12 data kept");

    do_write(6, 8'hC3);
    @(negedge clk); hw_store_n = 0;
    @(negedge clk); hw_store_n = 1; ce_n = 0; we_n = 0; addr = 6; wdata = 8'h77;
    chk("R5 hw store busy", busy, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R11 held write not dirty", dirty, 0);
    ce_n = 1; we_n = 1;
    do_read(6, 8'hC3, "R11 held write blocked");
    do_write(6, 8'h77);
    do_read(6, 8'h77, "R11 fresh write accepted");

    do_write(7, 8'h3C);
    @(negedge clk); pwr_fail = 1; sw_recall = 1;
    @(negedge clk); sw_recall = 0;
    chk("R10 store wins", busy, 1);
    wait_idle();
    do_read(7, 8'h3C, "R10 image kept");
    chk("R10 dirty cleared", dirty, 0);

    do_write(7, 8'h99);
    @(negedge clk); pwr_fail = 0;
    @(negedge clk);
    chk("R4 power-up recall busy", busy, 1);
    wait_idle();
    do_read(7, 8'h3C, "R4 recall after power cycle");
    do_read(6, 8'h77, "R8 whole image copied");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule